// File: doc/BRIEF.md
# Indexed Palette DAC Port

This block is the processor-side register port of a colour lookup table. The table holds 256 main entries and a small overlay bank of 4 entries. Each entry has 8-bit red, green and blue values. Software first loads a colour index through one register. It then streams colour components through a data register, always red first, then green, then blue. After each complete triple the index moves on by itself, so a whole palette can be loaded with one index write followed by a stream of component writes. Reads of components walk through the same sequence.

A second data register targets the overlay bank. It uses the low bits of the same index and the same component sequence. The main and overlay accesses share one sequencer, so they can be mixed within a single triple. Two registered lookup ports serve the display side. One returns the packed colour of any main entry, the other the colour of any overlay entry, each one cycle after the index is presented. Pixel format conversion and the analog converter lie outside this block.

Top module: `palette_dac_port`

## Requirements
- R1: A write at byte offset 0 loads the colour index from bus data bits 31:24 and sets the component sequence to red.
- R2: Writes at byte offset 4 store bus data bits 31:24 into the main entry at the current index. Successive writes fill red, green and blue in that order.
- R3: When blue is stored or read, the index advances by one and wraps from 255 to 0, and the sequence returns to red. A red or green access leaves the index unchanged.
- R4: Writes at byte offset 12 store into overlay entry (index mod 4), with the same component order and the same index advance as R2 and R3.
- R5: A read returns the current component of the main entry at the current index in bits 31:24, with bits 23:0 zero. The value appears on the cycle after the read strobe, is held until the next read, and advances the sequence exactly as a write does.
- R6: Writes at any other byte offset (for example 8, 1, 2, 3, 5..11, 13..15) change no entry, the index or the sequence.
- R7: After reset all main entries are black except entry 255, overlay entries 0 and 2 are white and overlay entries 1 and 3 are black. The index is 0, the sequence is at red and read data is 0.
- R8: The pixel port returns {red, green, blue} of main entry pix_index in bits 23:16, 15:8 and 7:0, registered, one cycle after the index is presented.
- R9: The overlay port returns the packed colour of overlay entry ovl_sel in the same layout, one cycle after the select is presented.
- R10: Main writes, overlay writes and reads share a single component sequence, so a triple may mix them and each access consumes the next component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | 32-bit write strobe |
| bus_rd | input | 1 | 32-bit read strobe (never together with bus_wr) |
| bus_addr | input | 4 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pix_index | input | 8 | Main entry to look up |
| pix_color | output | 24 | Packed colour of the looked-up main entry |
| ovl_sel | input | 2 | Overlay entry to look up |
| ovl_color | output | 24 | Packed colour of the selected overlay entry |

## Verification
The bench streams a distinct arithmetic pattern into all 768 main components from a single index load. It then checks every entry through the pixel port and through a second full streamed read. A wrong component order, a missed auto-increment or a bad wrap from 255 to 0 each give different mismatches. Overlay writes started at several indices show whether the overlay bank is addressed by the index modulo 4. A sweep of every non-decoded offset, followed by a single red write, shows that those writes neither store data nor move the sequence. A triple that mixes main writes, a read and overlay writes shows whether the three access kinds share one sequencer.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chan_e;

  localparam int unsigned NCH = 3;

  // Component that follows a given one in the stream order.
  function automatic chan_e chan_next(chan_e c);
    case (c)
      CH_RED:  return CH_GRN;
      CH_GRN:  return CH_BLU;
      default: return CH_RED;
    endcase
  endfunction

  // Overlay slots that come out of reset white.
  function automatic bit ovl_reset_white(int unsigned slot);
    return (slot == 0) || (slot == 2);
  endfunction

endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [IDX_W-1:0] ld_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output chan_e            chan,
  output logic             wrap
);

  // Asserted on a step that consumes the last component of a triple.
  assign wrap = step && (chan == CH_BLU);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      chan <= CH_RED;
    end else if (ld) begin
      idx  <= ld_val;
      chan <= CH_RED;
    end else if (step) begin
      chan <= chan_next(chan);
      if (wrap) idx <= idx + 1'b1;
    end
  end

  // R1
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (idx == $past(ld_val)) && (chan == CH_RED));

  // R3
  index_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && chan == CH_BLU) |=>
      (idx == IDX_W'($past(idx) + 1'b1)) && (chan == CH_RED));

  // R3
  index_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && chan != CH_BLU) |=> $stable(idx));

  // R10
  chan_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan != 2'd3);

endmodule

// File: rtl/pal_bank.sv
module pal_bank
  import pal_pkg::*;
#(
  parameter int unsigned MAIN_N = 256,
  parameter int unsigned OVL_N  = 4,
  parameter int unsigned CW     = 8,
  localparam int unsigned IDX_W = $clog2(MAIN_N),
  localparam int unsigned OVL_W = $clog2(OVL_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_main,
  input  logic             wr_ovl,
  input  logic [IDX_W-1:0] widx,
  input  chan_e            wchan,
  input  logic [CW-1:0]    wval,
  output logic [CW-1:0]    cpu_val,
  input  logic [IDX_W-1:0] px_idx,
  output logic [3*CW-1:0]  px_color,
  input  logic [OVL_W-1:0] ov_idx,
  output logic [3*CW-1:0]  ov_color
);

  logic [CW-1:0] main_mem [MAIN_N][NCH];
  logic [CW-1:0] ovl_mem  [OVL_N][NCH];
  logic [OVL_W-1:0] wslot;

  assign wslot   = widx[OVL_W-1:0];
  assign cpu_val = main_mem[widx][wchan];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAIN_N; i++)
        for (int c = 0; c < NCH; c++)
          main_mem[i][c] <= (i == MAIN_N - 1) ? '1 : '0;
      for (int j = 0; j < OVL_N; j++)
        for (int c = 0; c < NCH; c++)
          ovl_mem[j][c] <= ovl_reset_white(j) ? '1 : '0;
    end else begin
      if (wr_main) main_mem[widx][wchan] <= wval;
      if (wr_ovl)  ovl_mem[wslot][wchan] <= wval;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_color <= '0;
      ov_color <= '0;
    end else begin
      px_color <= {main_mem[px_idx][CH_RED], main_mem[px_idx][CH_GRN], main_mem[px_idx][CH_BLU]};
      ov_color <= {ovl_mem[ov_idx][CH_RED], ovl_mem[ov_idx][CH_GRN], ovl_mem[ov_idx][CH_BLU]};
    end
  end

  // R2
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_main && wr_ovl));

endmodule

// File: rtl/palette_dac_port.sv
module palette_dac_port
  import pal_pkg::*;
#(
  parameter int unsigned MAIN_N = 256,
  parameter int unsigned OVL_N  = 4,
  parameter int unsigned CW     = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW     = 32,
  localparam int unsigned IDX_W = $clog2(MAIN_N),
  localparam int unsigned OVL_W = $clog2(OVL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [IDX_W-1:0]  pix_index,
  output logic [3*CW-1:0]   pix_color,
  input  logic [OVL_W-1:0]  ovl_sel,
  output logic [3*CW-1:0]   ovl_color
);

  localparam logic [ADDR_W-1:0] OFF_INDEX = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MAIN  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_OVL   = ADDR_W'(12);

  logic             ev_load, ev_wr_main, ev_wr_ovl, ev_read, ev_step, ev_wrap, ev_ignored;
  logic [IDX_W-1:0] cur_idx;
  chan_e            cur_chan;
  logic [CW-1:0]    cpu_val;
  logic [CW-1:0]    wr_byte;

  assign ev_load    = bus_wr && (bus_addr == OFF_INDEX);
  assign ev_wr_main = bus_wr && (bus_addr == OFF_MAIN);
  assign ev_wr_ovl  = bus_wr && (bus_addr == OFF_OVL);
  assign ev_read    = bus_rd && !bus_wr;
  assign ev_step    = ev_wr_main || ev_wr_ovl || ev_read;
  assign ev_ignored = bus_wr && !ev_load && !ev_wr_main && !ev_wr_ovl;
  assign wr_byte    = bus_wdata[DW-1 -: CW];

  pal_seq #(.IDX_W(IDX_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ev_load),
    .ld_val (bus_wdata[DW-1 -: IDX_W]),
    .step   (ev_step),
    .idx    (cur_idx),
    .chan   (cur_chan),
    .wrap   (ev_wrap)
  );

  pal_bank #(.MAIN_N(MAIN_N), .OVL_N(OVL_N), .CW(CW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_main  (ev_wr_main),
    .wr_ovl   (ev_wr_ovl),
    .widx     (cur_idx),
    .wchan    (cur_chan),
    .wval     (wr_byte),
    .cpu_val  (cpu_val),
    .px_idx   (pix_index),
    .px_color (pix_color),
    .ov_idx   (ovl_sel),
    .ov_color (ovl_color)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       bus_rdata <= '0;
    else if (ev_read) bus_rdata <= {cpu_val, {(DW-CW){1'b0}}};
  end

  // R5
  rdata_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |=> (bus_rdata[DW-CW-1:0] == '0));

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R6
  ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ignored && !bus_rd) |=> ($stable(cur_idx) && $stable(cur_chan)));

  // R3
  wrap_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wrap && !ev_load) |=> (cur_chan == CH_RED));

endmodule

// File: tb/sim_palette_dac_port.sv
module sim_palette_dac_port;
  localparam int PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_index = 0;
  logic [23:0] pix_color;
  logic [1:0]  ovl_sel = 0;
  logic [23:0] ovl_color;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_main [256][3];
  logic [7:0] m_ovl  [4][3];
  int m_idx = 0, m_ch = 0;

  palette_dac_port u0 (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(int i, int c);
    return 8'((i * 37 + c * 91 + 5) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic model_step();
    if (m_ch == 2) begin m_ch = 0; m_idx = (m_idx + 1) & 255; end
    else m_ch++;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = {d, 24'h5A5A5A};
    @(negedge clk);
    bus_wr = 0;
    if (a == 0) begin m_idx = d; m_ch = 0; end
    else if (a == 4) begin m_main[m_idx][m_ch] = d; model_step(); end
    else if (a == 12) begin m_ovl[m_idx & 3][m_ch] = d; model_step(); end
  endtask

  task automatic rd(string req);
    logic [7:0] e;
    @(negedge clk);
    bus_rd = 1;
    e = m_main[m_idx][m_ch];
    @(negedge clk);
    bus_rd = 0;
    check(req, bus_rdata, {e, 24'h0});
    model_step();
  endtask

  task automatic px(string req, int i);
    @(negedge clk);
    pix_index = 8'(i);
    @(negedge clk);
    check(req, {8'h0, pix_color}, {8'h0, m_main[i][0], m_main[i][1], m_main[i][2]});
  endtask

  task automatic ov(string req, int s);
    @(negedge clk);
    ovl_sel = 2'(s);
    @(negedge clk);
    check(req, {8'h0, ovl_color}, {8'h0, m_ovl[s][0], m_ovl[s][1], m_ovl[s][2]});
  endtask

  initial begin
    #(PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) m_main[i][c] = (i == 255) ? 8'hFF : 8'h00;
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 3; c++) m_ovl[s][c] = (s == 0 || s == 2) ? 8'hFF : 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R7 reset state
    check("R7 rdata", bus_rdata, 32'h0);
    for (int i = 0; i < 256; i++) px("R7 main reset", i);
    for (int s = 0; s < 4; s++) ov("R7 overlay reset", s);
    rd("R7 R5 index0 red after reset");
    // R1 R2 R3 full stream from index 0, wraps 255 -> 0
    wr(0, 8'd0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) wr(4, pat(i, c));
    for (int i = 0; i < 256; i++) px("R2 R8 streamed entry", i);
    // R3 wrap: next red write lands on entry 0
    wr(4, 8'hC3);
    px("R3 wrap to entry 0", 0);
    // R5 full streamed read, R1 reloads red
    wr(0, 8'd0);
    for (int i = 0; i < 768; i++) rd("R5 R3 streamed read");
    // R4 overlay addressed by index mod 4
    wr(0, 8'd6);
    for (int k = 0; k < 9; k++) wr(12, 8'(8'h11 * (k + 1)));
    for (int s = 0; s < 4; s++) ov("R4 R9 overlay", s);
    px("R4 main untouched", 6);
    wr(0, 8'd253);
    for (int k = 0; k < 3; k++) wr(12, 8'(8'h40 + k));
    ov("R4 overlay slot1", 1);
    // R6 ignored offsets
    wr(0, 8'd20);
    wr(4, 8'h01);
    for (int a = 1; a < 16; a++)
      if (a != 4 && a != 12) wr(4'(a), 8'hEE);
    for (int s = 0; s < 4; s++) ov("R6 overlay unchanged", s);
    wr(4, 8'h02);
    px("R6 sequence unmoved", 20);
    px("R6 neighbour unchanged", 21);
    // R10 mixed triple
    wr(0, 8'd40);
    wr(4, 8'hA1);
    rd("R10 read takes green");
    wr(12, 8'hB3);
    px("R10 mixed main", 40);
    ov("R10 mixed overlay", 0);
    wr(4, 8'h77);
    px("R10 R3 next index red", 41);
    summary();
  end
endmodule